// File: doc/BRIEF.md
# ModR/M Operand Address Sequencer

This block sits in the operand stage of an instruction decoder. It receives the instruction stream one byte per cycle, starting at the addressing byte that follows the opcode. It splits that byte into its mode, register and base fields and reads the base register through a read port into an external eight-entry, 32-bit register file. It then collects any displacement bytes that follow and delivers the final memory address together with a one-cycle completion strobe.

Depending on the mode, the block collects zero, one or four displacement bytes. There is one exception to the normal rule. When the mode is 00 and the base field is 101, no register is used, and the four bytes that follow form an absolute address. In register-direct mode, the block reports the register index instead of an address. Base field 100 in any memory mode needs a scale-index byte, which this block does not decode, so it is reported as an error.

The result fields are registered. They stay stable from one completion strobe to the next. As soon as the strobe rises, the block will accept the next addressing byte.

Top module: `ea_sequencer`

## Requirements
- R1: At each `done`, `reg_field` equals bits 5:3 and `rm_idx` equals bits 2:0 of the addressing byte the result belongs to. `rf_idx` always shows bits 2:0 of `byte_data`.
- R2: In mode 00 with a base field other than 100 or 101, `done` rises in the cycle after the addressing byte is accepted.
  - `ea` is the register value presented on `rf_data` during the cycle the addressing byte was accepted.
  - `disp_len` is 0.
- R3: In mode 00 with base field 101, the next four accepted bytes form `ea`, least significant byte first (bytes 78 56 34 12 give 0x12345678).
  - No register value is added.
  - `disp_len` is 4.
- R4: In mode 01, one displacement byte follows. It is sign-extended and added to the base register, so 0xff subtracts one. `disp_len` is 1.
- R5: In mode 10, four little-endian displacement bytes follow and are added to the base register, so ff ff ff ff subtracts one. `disp_len` is 4.
- R6: The address sum wraps modulo 2^32.
- R7: In mode 11, `done` rises in the cycle after the addressing byte is accepted.
  - `is_reg` is 1 and `rm_idx` carries the register index.
  - `ea` is 0, `disp_len` is 0 and `sib_err` is 0.
- R8: Base field 100 in modes 00, 01 and 10 ends the operand at once.
  - `sib_err` is 1 and `ea` is 0.
  - No further byte is consumed, so the next valid byte is taken as a new addressing byte.
- R9: `done` is high for exactly one cycle per operand. That cycle comes right after the operand's last byte is accepted. Cycles where `byte_valid` is low during displacement collection only delay it.
- R10: The result fields hold their values between strobes. In the cycle where `done` is high, a new addressing byte is accepted.
- R11: After synchronous reset, `done`, `ea`, `is_reg`, `sib_err` and `disp_len` are all 0, and the block waits for an addressing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Stream byte present this cycle |
| byte_data | input | 8 | Stream byte |
| rf_idx | output | 3 | Register file read index |
| rf_data | input | 32 | Register file read data for `rf_idx` |
| done | output | 1 | One-cycle result strobe |
| ea | output | 32 | Effective address |
| is_reg | output | 1 | Operand is a register (mode 11) |
| rm_idx | output | 3 | Base / register field of the operand |
| reg_field | output | 3 | Register or sub-opcode field |
| disp_len | output | 3 | Displacement bytes consumed (0, 1 or 4) |
| sib_err | output | 1 | Unsupported scale-index form |

## Verification
Two things can land in the same cycle: the completion strobe for one operand and the acceptance of the next addressing byte. The bench provokes this by driving a new addressing byte in the very cycle where the previous result is being checked. It then confirms two things. First, the earlier result is intact while the strobe is high. Second, the new operand completes with its own register read and its own displacement. A second pair comes from the error case, where an unsupported base field ends the operand at once. The byte that follows must then be decoded as a fresh addressing byte rather than swallowed as a displacement.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        MD_IND = 2'b00,
        MD_D8  = 2'b01,
        MD_D32 = 2'b10,
        MD_REG = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        DK_NONE,
        DK_SHORT,
        DK_LONG
    } disp_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_DISP
    } seq_state_e;

    localparam logic [2:0] RM_ESC_SIB = 3'b100;
    localparam logic [2:0] RM_ABS     = 3'b101;

    typedef struct packed {
        addr_mode_e mode;
        logic [2:0] reg_f;
        logic [2:0] rm;
        logic       reg_direct;
        logic       sib_form;
        logic       use_base;
        disp_kind_e kind;
    } modrm_dec_t;

    function automatic logic abs_form(input addr_mode_e m, input logic [2:0] rm);
        return (m == MD_IND) && (rm == RM_ABS);
    endfunction

endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode
    import ea_pkg::*;
(
    input  logic [7:0]  modrm,
    output modrm_dec_t  dec
);
    always_comb begin
        dec.mode       = addr_mode_e'(modrm[7:6]);
        dec.reg_f      = modrm[5:3];
        dec.rm         = modrm[2:0];
        dec.reg_direct = (dec.mode == MD_REG);
        dec.sib_form   = !dec.reg_direct && (dec.rm == RM_ESC_SIB);
        dec.use_base   = !dec.reg_direct && !dec.sib_form && !abs_form(dec.mode, dec.rm);
        if (dec.reg_direct || dec.sib_form)
            dec.kind = DK_NONE;
        else if (abs_form(dec.mode, dec.rm))
            dec.kind = DK_LONG;
        else if (dec.mode == MD_D8)
            dec.kind = DK_SHORT;
        else if (dec.mode == MD_D32)
            dec.kind = DK_LONG;
        else
            dec.kind = DK_NONE;
    end
endmodule

// File: rtl/ea_disp_collect.sv
module ea_disp_collect #(
    parameter int DISP_BYTES = 4,
    localparam int CNT_W     = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [7:0]              wr_byte,
    output logic [CNT_W-1:0]        cnt,
    output logic [8*DISP_BYTES-1:0] disp_next
);
    logic [7:0] lane_q [DISP_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (wr_en)
            cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
        logic hit;
        assign hit = wr_en && (cnt == CNT_W'(g));
        always_ff @(posedge clk) begin
            if (rst || clear)
                lane_q[g] <= '0;
            else if (hit)
                lane_q[g] <= wr_byte;
        end
        // least significant byte arrives first
        assign disp_next[8*g +: 8] = hit ? wr_byte : lane_q[g];
    end
endmodule

// File: rtl/ea_addr_add.sv
module ea_addr_add
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] disp_raw,
    input  disp_kind_e        kind,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        unique case (kind)
            DK_SHORT: disp_ext = {{(ADDR_W-8){disp_raw[7]}}, disp_raw[7:0]};
            DK_LONG:  disp_ext = disp_raw;
            default:  disp_ext = '0;
        endcase
        sum = base + disp_ext;
    end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int DISP_BYTES = ADDR_W / 8,
    localparam int LEN_W = $clog2(DISP_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic [2:0]        rf_idx,
    input  logic [ADDR_W-1:0] rf_data,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              is_reg,
    output logic [2:0]        rm_idx,
    output logic [2:0]        reg_field,
    output logic [LEN_W-1:0]  disp_len,
    output logic              sib_err
);
    localparam int CNT_W = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DISP_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = '0;

    seq_state_e        state_q;
    disp_kind_e        kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [2:0]        rm_q, reg_q;
    modrm_dec_t        dec;
    logic              accept, disp_wr, last_byte, finish_now;
    logic [CNT_W-1:0]  cnt, last_cnt;
    logic [ADDR_W-1:0] disp_next, sum;

    assign rf_idx = byte_data[2:0];

    ea_field_decode u_dec (
        .modrm (byte_data),
        .dec   (dec)
    );

    assign accept     = (state_q == ST_IDLE) && byte_valid;
    assign disp_wr    = (state_q == ST_DISP) && byte_valid;
    assign last_cnt   = (kind_q == DK_SHORT) ? LAST_SHORT : LAST_LONG;
    assign last_byte  = disp_wr && (cnt == last_cnt);
    assign finish_now = accept && (dec.kind == DK_NONE);

    ea_disp_collect #(.DISP_BYTES(DISP_BYTES)) u_col (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .wr_en     (disp_wr),
        .wr_byte   (byte_data),
        .cnt       (cnt),
        .disp_next (disp_next)
    );

    ea_addr_add #(.ADDR_W(ADDR_W)) u_add (
        .base     (base_q),
        .disp_raw (disp_next),
        .kind     (kind_q),
        .sum      (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= DK_NONE;
            base_q  <= '0;
            rm_q    <= '0;
            reg_q   <= '0;
        end else if (accept) begin
            kind_q  <= dec.kind;
            base_q  <= dec.use_base ? rf_data : '0;
            rm_q    <= dec.rm;
            reg_q   <= dec.reg_f;
            if (dec.kind != DK_NONE)
                state_q <= ST_DISP;
        end else if (last_byte) begin
            state_q <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            ea        <= '0;
            is_reg    <= 1'b0;
            rm_idx    <= '0;
            reg_field <= '0;
            disp_len  <= '0;
            sib_err   <= 1'b0;
        end else if (finish_now) begin
            done      <= 1'b1;
            ea        <= dec.use_base ? rf_data : '0;
            is_reg    <= dec.reg_direct;
            rm_idx    <= dec.rm;
            reg_field <= dec.reg_f;
            disp_len  <= '0;
            sib_err   <= dec.sib_form;
        end else if (last_byte) begin
            done      <= 1'b1;
            ea        <= sum;
            is_reg    <= 1'b0;
            rm_idx    <= rm_q;
            reg_field <= reg_q;
            disp_len  <= (kind_q == DK_SHORT) ? LEN_W'(1) : LEN_W'(DISP_BYTES);
            sib_err   <= 1'b0;
        end else begin
            done      <= 1'b0;
        end
    end
endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk #(
    parameter int ADDR_W = 32,
    localparam int DISP_BYTES = ADDR_W / 8,
    localparam int LEN_W = $clog2(DISP_BYTES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_valid,
    input logic              done,
    input logic [ADDR_W-1:0] ea,
    input logic              is_reg,
    input logic [LEN_W-1:0]  disp_len,
    input logic              sib_err
);
    a_r9_done_after_byte: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(byte_valid));

    a_r7_reg_no_disp: assert property (@(posedge clk) disable iff (rst)
        (done && is_reg) |-> (disp_len == '0 && !sib_err && ea == '0));

    a_r8_err_no_addr: assert property (@(posedge clk) disable iff (rst)
        (done && sib_err) |-> (!is_reg && ea == '0 && disp_len == '0));

    a_r10_hold_ea: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ea));

    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && ea == '0 && !is_reg && !sib_err));

    a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (disp_len == '0 || disp_len == LEN_W'(1) || disp_len == LEN_W'(DISP_BYTES)));
endmodule

bind ea_sequencer ea_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .done       (done),
    .ea         (ea),
    .is_reg     (is_reg),
    .disp_len   (disp_len),
    .sib_err    (sib_err)
);

// File: tb/test_ea_sequencer.sv
module test_ea_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [2:0]  rf_idx;
    logic [31:0] rf_data;
    logic        done;
    logic [31:0] ea;
    logic        is_reg;
    logic [2:0]  rm_idx;
    logic [2:0]  reg_field;
    logic [2:0]  disp_len;
    logic        sib_err;

    logic [31:0] regs [8];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign rf_data = regs[rf_idx];

    ea_sequencer i_ea_sequencer (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .rf_idx(rf_idx), .rf_data(rf_data), .done(done), .ea(ea), .is_reg(is_reg),
        .rm_idx(rm_idx), .reg_field(reg_field), .disp_len(disp_len), .sib_err(sib_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_res(input string tag, input logic [31:0] e_ea, input logic e_reg,
                           input logic [2:0] e_len, input logic e_err,
                           input logic [2:0] e_rm, input logic [2:0] e_rf);
        chk({tag, " done R9"}, 32'(done), 32'd1);
        chk({tag, " ea"}, ea, e_ea);
        chk({tag, " is_reg R7"}, 32'(is_reg), 32'(e_reg));
        chk({tag, " disp_len"}, 32'(disp_len), 32'(e_len));
        chk({tag, " sib_err R8"}, 32'(sib_err), 32'(e_err));
        chk({tag, " rm_idx R1"}, 32'(rm_idx), 32'(e_rm));
        chk({tag, " reg_field R1"}, 32'(reg_field), 32'(e_rf));
    endtask

    // sends addressing byte then n displacement bytes (LSB first), gap idle cycles before each
    task automatic send(input logic [7:0] m, input int n, input logic [31:0] d, input int gap);
        @(negedge clk); byte_valid = 1'b1; byte_data = m;
        for (int i = 0; i < n; i++) begin
            if (gap > 0) begin
                @(negedge clk); byte_valid = 1'b0; byte_data = 8'hxx;
                chk("R9 no done during stall", 32'(done), 32'd0);
                repeat (gap - 1) @(negedge clk);
            end
            @(negedge clk); byte_valid = 1'b1; byte_data = d[8*i +: 8];
        end
        @(negedge clk); byte_valid = 1'b0; byte_data = 8'h00;
    endtask

    task automatic t_reset;
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 ea", ea, 32'd0);
        chk("R11 is_reg", 32'(is_reg), 32'd0);
        chk("R11 sib_err", 32'(sib_err), 32'd0);
        chk("R11 disp_len", 32'(disp_len), 32'd0);
    endtask

    task automatic t_indirect;
        send(8'h18, 0, 0, 0);           // mode 00 reg 3 base 0
        chk_res("R2 ind eax", 32'h60, 0, 0, 0, 3'd0, 3'd3);
        send(8'h03, 0, 0, 0);           // mode 00 reg 0 base 3
        chk_res("R2 ind ebx", 32'h10, 0, 0, 0, 3'd3, 3'd0);
        @(negedge clk);
        chk("R9 single pulse", 32'(done), 32'd0);
        chk("R10 hold ea", ea, 32'h10);
        chk("R1 rf_idx follows byte", 32'(rf_idx), 32'(byte_data[2:0]));
    endtask

    task automatic t_absolute;
        send(8'h1d, 4, 32'h0000_0060, 0);
        chk_res("R3 abs 60", 32'h60, 0, 3'd4, 0, 3'd5, 3'd3);
        send(8'h05, 4, 32'h1234_5678, 0);
        chk_res("R3 abs order", 32'h1234_5678, 0, 3'd4, 0, 3'd5, 3'd0);
    endtask

    task automatic t_disp8;
        send(8'h59, 1, 32'h02, 0);      // 0x5e + 2
        chk_res("R4 d8 pos", 32'h60, 0, 3'd1, 0, 3'd1, 3'd3);
        send(8'h5a, 1, 32'hff, 0);      // 0x61 - 1
        chk_res("R4 d8 neg", 32'h60, 0, 3'd1, 0, 3'd2, 3'd3);
        send(8'h45, 1, 32'h20, 0);      // base 5 with disp8 uses register
        chk_res("R6 d8 wrap", 32'h10, 0, 3'd1, 0, 3'd5, 3'd0);
    endtask

    task automatic t_disp32;
        send(8'h99, 4, 32'h0000_0002, 0);
        chk_res("R5 d32 pos", 32'h60, 0, 3'd4, 0, 3'd1, 3'd3);
        send(8'h9a, 4, 32'hffff_ffff, 0);
        chk_res("R5 d32 neg", 32'h60, 0, 3'd4, 0, 3'd2, 3'd3);
        send(8'hb6, 4, 32'h8000_0001, 0); // 0x80000000 + 0x80000001
        chk_res("R6 d32 wrap", 32'h1, 0, 3'd4, 0, 3'd6, 3'd6);
    endtask

    task automatic t_register;
        send(8'hc3, 0, 0, 0);
        chk_res("R7 reg direct", 32'h0, 1, 0, 0, 3'd3, 3'd0);
    endtask

    task automatic t_sib;
        send(8'h04, 0, 0, 0);
        chk_res("R8 sib mode00", 32'h0, 0, 0, 1, 3'd4, 3'd0);
        // mode 01 base 100: the next byte must be a fresh addressing byte
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h44;
        @(negedge clk); byte_data = 8'h18;
        chk_res("R8 sib mode01", 32'h0, 0, 0, 1, 3'd4, 3'd0);
        @(negedge clk); byte_valid = 1'b0;
        chk_res("R8 next byte fresh", 32'h60, 0, 0, 0, 3'd0, 3'd3);
    endtask

    task automatic t_back_to_back;
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h18;
        @(negedge clk); byte_data = 8'h59;   // accepted while done is high
        chk_res("R10 first", 32'h60, 0, 0, 0, 3'd0, 3'd3);
        @(negedge clk); byte_data = 8'hfe;   // disp8 = -2
        chk("R9 waiting disp", 32'(done), 32'd0);
        chk("R10 hold while busy", ea, 32'h60);
        @(negedge clk); byte_valid = 1'b0;
        chk_res("R10 second", 32'h5c, 0, 3'd1, 0, 3'd1, 3'd3);
    endtask

    task automatic t_stall;
        send(8'h1d, 4, 32'hcafe_0040, 2);
        chk_res("R9 stalled abs", 32'hcafe_0040, 0, 3'd4, 0, 3'd5, 3'd3);
    endtask

    initial begin
        regs[0] = 32'h60; regs[1] = 32'h5e; regs[2] = 32'h61; regs[3] = 32'h10;
        regs[4] = 32'h14; regs[5] = 32'hffff_fff0; regs[6] = 32'h8000_0000; regs[7] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_indirect();
        t_absolute();
        t_disp8();
        t_disp32();
        t_register();
        t_sib();
        t_back_to_back();
        t_stall();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule